// File: doc/BRIEF.md
# Bypassed Register File with Two-Deep Write History

This block is a register file with one write port and one read port, built for use inside an elastic pipeline. A write does not reach the storage array at once. It travels through two history slots, one per clock, and is committed to the array on the edge that retires it from the second slot. Every read compares its address against both history slots. The value returned is the one from the youngest matching in-flight write, or from the array when nothing matches. A read-after-write dependency on a recent write therefore does not need a stall.

A producer may issue a write whose address is known before its data. It drives `wr_data_ok` low with the write. The data then arrives one cycle later on `wr_late_data`. While such a write sits in the first history slot, a read of its address raises `hazard`. The surrounding elastic controller uses that flag to hold its stop signal for one cycle. This is the only case in which the block asks the pipeline to wait.

All pins are plain control and data pins, with no valid/ready handshake. The pipeline around the block owns flow control: a held stage simply repeats its read address, and the block answers combinationally in the same cycle. The parameter `ZERO_R0` turns entry 0 into a constant-zero register.

Top module: `rfb_regfile`

## Requirements
- R1: While reset is high and in the cycle after it falls, every read returns 0 and `hazard` is low, because the array and the history are cleared by reset.
- R2: A write issued in cycle t with `wr_en`=1 and `wr_data_ok`=1 is returned by a read of the same address in cycle t+1.
- R3: The same write is returned by a read of that address in cycle t+2, provided no younger write to that address is in flight.
- R4: From cycle t+3 on, the write's value comes from the array and persists until a later write to that address replaces it.
- R5: When both history slots hold writes to the read address, the younger write (issued one cycle back) is returned.
- R6: A cycle with `wr_en`=0 changes no register and creates no bypass match, whatever `wr_addr` and `wr_data` carry.
- R7: A read in the same cycle as a write to the same address returns the value held before that write.
- R8: A write issued in cycle t with `wr_data_ok`=0 makes a read of its address in cycle t+1 raise `hazard`. The value on `wr_late_data` in cycle t+1 becomes that address's value, which reads see from cycle t+2 on.
- R9: `hazard` is high only when the read address equals the address of a write issued one cycle earlier with `wr_en`=1 and `wr_data_ok`=0. In particular, an older late write that has already received its data never raises it.
- R10: With `ZERO_R0`=1, a read of address 0 always returns 0 with `hazard` low, and writes to address 0 are dropped. With `ZERO_R0`=0 (the default), entry 0 behaves like every other entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Issues a write this cycle |
| wr_addr | input | AW | Write address |
| wr_data | input | DATA_W | Write data, used when `wr_data_ok` is 1 |
| wr_data_ok | input | 1 | 1: data is present now; 0: data follows next cycle |
| wr_late_data | input | DATA_W | Deferred data for a write issued one cycle earlier with `wr_data_ok`=0 |
| rd_addr | input | AW | Read address |
| rd_data | output | DATA_W | Read value, combinational from `rd_addr` |
| hazard | output | 1 | Read matches an in-flight write whose data has not arrived |

## Verification
The bench targets the following cases.

- **Two same-address writes in a row, then a read.** A mux that ranks the older slot first would return the stale value.
- **A read in the cycle after the write, and again two cycles after it.** A design that skipped one history level, or committed to the array a cycle early or late, would show a gap of old data at the slot boundary.
- **A late write read while pending, then read again.** A design with a wrong hazard rule would stay silent, or flag a completed entry. One that mishandled the deferred data would commit garbage.
- **Idle cycles with junk on the address and data pins, and same-cycle read-write collisions.** These catch a compare that ignores enable and a bypass taken from the current-cycle input. A second instance with `ZERO_R0` set confirms that address 0 can be neither written nor forwarded.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

  // Source chosen by the read-side priority mux.
  typedef enum logic [1:0] {
    SRC_ARRAY = 2'd0,
    SRC_HIST1 = 2'd1,
    SRC_HIST2 = 2'd2
  } rfb_src_e;

endpackage

// File: rtl/rfb_array.sv
module rfb_array #(
  parameter int DEPTH   = 32,
  parameter int DATA_W  = 32,
  parameter int ZERO_R0 = 0,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cm_en,
  input  logic [AW-1:0]     cm_addr,
  input  logic [DATA_W-1:0] cm_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    if (ZERO_R0 != 0 && g == 0) begin : g_const
      assign mem[g] = '0;
    end else begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)
          mem[g] <= '0;
        else if (cm_en && cm_addr == AW'(g))
          mem[g] <= cm_data;
      end
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/rfb_history.sv
module rfb_history #(
  parameter int DEPTH   = 32,
  parameter int DATA_W  = 32,
  parameter int ZERO_R0 = 0,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_data_ok,
  input  logic [DATA_W-1:0] wr_late_data,
  output logic              h1_live,
  output logic [AW-1:0]     h1_addr,
  output logic [DATA_W-1:0] h1_data,
  output logic              h1_ready,
  output logic              h2_live,
  output logic [AW-1:0]     h2_addr,
  output logic [DATA_W-1:0] h2_data
);

  logic accept;

  // A write to the constant entry is dropped before it can match anything.
  always_comb begin
    accept = wr_en;
    if (ZERO_R0 != 0 && wr_addr == '0) accept = 1'b0;
  end

  // Slot 1: write issued one cycle back, data possibly still missing.
  always_ff @(posedge clk) begin
    if (rst) begin
      h1_live  <= 1'b0;
      h1_addr  <= '0;
      h1_data  <= '0;
      h1_ready <= 1'b0;
    end else begin
      h1_live  <= accept;
      h1_addr  <= wr_addr;
      h1_data  <= wr_data;
      h1_ready <= wr_data_ok;
    end
  end

  // Slot 2: always carries complete data; deferred data joins here.
  always_ff @(posedge clk) begin
    if (rst) begin
      h2_live <= 1'b0;
      h2_addr <= '0;
      h2_data <= '0;
    end else begin
      h2_live <= h1_live;
      h2_addr <= h1_addr;
      h2_data <= h1_ready ? h1_data : wr_late_data;
    end
  end

endmodule

// File: rtl/rfb_fwd.sv
module rfb_fwd
  import rfb_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic [AW-1:0]     rd_addr,
  input  logic [DATA_W-1:0] arr_data,
  input  logic              h1_live,
  input  logic [AW-1:0]     h1_addr,
  input  logic [DATA_W-1:0] h1_data,
  input  logic              h1_ready,
  input  logic              h2_live,
  input  logic [AW-1:0]     h2_addr,
  input  logic [DATA_W-1:0] h2_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              hazard
);

  logic     hit1, hit2;
  rfb_src_e src;

  assign hit1 = h1_live && (h1_addr == rd_addr);
  assign hit2 = h2_live && (h2_addr == rd_addr);

  // Youngest match first.
  always_comb begin
    if (hit1)      src = SRC_HIST1;
    else if (hit2) src = SRC_HIST2;
    else           src = SRC_ARRAY;
  end

  always_comb begin
    unique case (src)
      SRC_HIST1: rd_data = h1_data;
      SRC_HIST2: rd_data = h2_data;
      default:   rd_data = arr_data;
    endcase
  end

  assign hazard = hit1 && !h1_ready;

endmodule

// File: rtl/rfb_regfile.sv
module rfb_regfile #(
  parameter int DEPTH   = 32,
  parameter int DATA_W  = 32,
  parameter int ZERO_R0 = 0,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_data_ok,
  input  logic [DATA_W-1:0] wr_late_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              hazard
);

  logic              h1_live, h1_ready, h2_live;
  logic [AW-1:0]     h1_addr, h2_addr;
  logic [DATA_W-1:0] h1_data, h2_data, arr_data;

  rfb_history #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ZERO_R0(ZERO_R0)) u_hist (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_data_ok(wr_data_ok), .wr_late_data(wr_late_data),
    .h1_live(h1_live), .h1_addr(h1_addr), .h1_data(h1_data), .h1_ready(h1_ready),
    .h2_live(h2_live), .h2_addr(h2_addr), .h2_data(h2_data)
  );

  // The entry leaving slot 2 is committed to the array.
  rfb_array #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ZERO_R0(ZERO_R0)) u_arr (
    .clk(clk), .rst(rst),
    .cm_en(h2_live), .cm_addr(h2_addr), .cm_data(h2_data),
    .rd_addr(rd_addr), .rd_data(arr_data)
  );

  rfb_fwd #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fwd (
    .rd_addr(rd_addr), .arr_data(arr_data),
    .h1_live(h1_live), .h1_addr(h1_addr), .h1_data(h1_data), .h1_ready(h1_ready),
    .h2_live(h2_live), .h2_addr(h2_addr), .h2_data(h2_data),
    .rd_data(rd_data), .hazard(hazard)
  );

endmodule

// File: rtl/rfb_regfile_chk.sv
module rfb_regfile_chk #(
  parameter int DEPTH   = 32,
  parameter int DATA_W  = 32,
  parameter int ZERO_R0 = 0,
  localparam int AW = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_data_ok,
  input logic [DATA_W-1:0] wr_late_data,
  input logic [AW-1:0]     rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              hazard
);

  // Port-level record of the last two writes.
  logic              c1_live, c1_ok, c2_live;
  logic [AW-1:0]     c1_addr, c2_addr;
  logic [DATA_W-1:0] c1_data, c2_data;
  logic              keep;

  assign keep = wr_en && !(ZERO_R0 != 0 && wr_addr == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      c1_live <= 1'b0; c1_ok <= 1'b0; c1_addr <= '0; c1_data <= '0;
      c2_live <= 1'b0; c2_addr <= '0; c2_data <= '0;
    end else begin
      c1_live <= keep; c1_ok <= wr_data_ok; c1_addr <= wr_addr; c1_data <= wr_data;
      c2_live <= c1_live; c2_addr <= c1_addr;
      c2_data <= c1_ok ? c1_data : wr_late_data;
    end
  end

  // R2
  fwd_young_chk: assert property (@(posedge clk) disable iff (rst)
    (c1_live && c1_ok && c1_addr == rd_addr) |-> rd_data == c1_data);

  // R3
  fwd_old_chk: assert property (@(posedge clk) disable iff (rst)
    (c2_live && c2_addr == rd_addr && !(c1_live && c1_addr == rd_addr))
      |-> rd_data == c2_data);

  // R8
  late_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (c1_live && !c1_ok && c1_addr == rd_addr) |-> hazard);

  // R9
  flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
    hazard |-> (c1_live && !c1_ok && c1_addr == rd_addr));

  // R10
  zero_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (ZERO_R0 != 0 && rd_addr == '0) |-> (rd_data == '0 && !hazard));

endmodule

bind rfb_regfile rfb_regfile_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ZERO_R0(ZERO_R0)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_data_ok(wr_data_ok), .wr_late_data(wr_late_data), .rd_addr(rd_addr),
  .rd_data(rd_data), .hazard(hazard)
);

// File: tb/sim_rfb_regfile.sv
`timescale 1ns/1ps
module sim_rfb_regfile;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_data_ok = 1'b1;
  logic [4:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, wr_late_data = '0;
  logic [31:0] rd0, rd1;
  logic        hz0, hz1;

  int checks = 0;
  int fails  = 0;

  // Behavioural model: logical register contents plus one pending late write.
  logic [31:0] ref0 [32];
  logic [31:0] ref1 [32];
  logic        p_late = 1'b0;
  int          p_addr = 0;

  always #2.5 clk = ~clk;

  rfb_regfile u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_data_ok(wr_data_ok), .wr_late_data(wr_late_data), .rd_addr(rd_addr),
    .rd_data(rd0), .hazard(hz0)
  );

  rfb_regfile #(.ZERO_R0(1)) u1 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_data_ok(wr_data_ok), .wr_late_data(wr_late_data), .rd_addr(rd_addr),
    .rd_data(rd1), .hazard(hz1)
  );

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Compare both instances against the model at the falling edge.
  task automatic check_now(string tag);
    int  a = int'(rd_addr);
    logic eh0 = p_late && p_addr == a;
    logic eh1 = eh0 && a != 0;
    cmp(tag, "u0 hazard", {31'd0, hz0}, {31'd0, eh0});
    if (!eh0) cmp(tag, "u0 rd_data", rd0, ref0[a]);
    cmp(tag, "u1 hazard", {31'd0, hz1}, {31'd0, eh1});
    if (!eh1) cmp(tag, "u1 rd_data", rd1, (a == 0) ? 32'd0 : ref1[a]);
  endtask

  // One cycle: drive inputs, check, then advance the model at the edge.
  task automatic step(logic we, int wa, logic [31:0] wd, logic ok,
                      logic [31:0] late, int ra, string tag);
    wr_en = we; wr_addr = 5'(wa); wr_data = wd; wr_data_ok = ok;
    wr_late_data = late; rd_addr = 5'(ra);
    @(negedge clk);
    check_now(tag);
    @(posedge clk);
    if (p_late) begin
      ref0[p_addr] = late;
      if (p_addr != 0) ref1[p_addr] = late;
    end
    p_late = 1'b0;
    if (we) begin
      if (ok) begin
        ref0[wa] = wd;
        if (wa != 0) ref1[wa] = wd;
      end
      p_late = !ok;
      p_addr = wa;
    end
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) begin ref0[i] = '0; ref1[i] = '0; end
    // R1: outputs during reset
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < 4; i++) begin
      rd_addr = 5'(i * 7);
      @(negedge clk);
      cmp("R1", "rd_data in reset", rd0, 32'd0);
      cmp("R1", "hazard in reset", {31'd0, hz0}, 32'd0);
      @(posedge clk); #1;
    end
    rst = 1'b0;
    step(0, 0, 0, 1, 0, 9,  "R1");
    step(0, 0, 0, 1, 0, 31, "R1");

    // R2 / R7: write 7, read the same address in the same cycle, then next cycle
    step(1, 7, 32'h1111_0007, 1, 0, 7, "R7");
    step(0, 0, 0, 1, 0, 7, "R2");
    // R3: read two cycles after, with an unrelated write in between
    step(1, 8, 32'h2222_0008, 1, 0, 3, "R3");
    step(0, 0, 0, 1, 0, 8, "R3");
    // R4: value persists from the array
    step(0, 0, 0, 1, 0, 7, "R4");
    step(0, 0, 0, 1, 0, 8, "R4");

    // R5: back-to-back writes to one address, read while both are in flight
    step(1, 12, 32'hAAAA_0001, 1, 0, 12, "R5");
    step(1, 12, 32'hBBBB_0002, 1, 0, 12, "R5");
    step(0, 0, 0, 1, 0, 12, "R5");
    step(0, 0, 0, 1, 0, 12, "R5");

    // R6: junk on the write pins with enable low
    step(0, 12, 32'hDEAD_BEEF, 1, 0, 12, "R6");
    step(0, 12, 32'hDEAD_BEEF, 0, 0, 12, "R6");
    step(0, 0, 0, 1, 0, 12, "R6");

    // R8: late write, hazard next cycle, late data becomes visible after
    step(1, 20, 32'hFFFF_FFFF, 0, 0, 1, "R8");
    step(0, 0, 0, 1, 32'h5A5A_0020, 20, "R8");
    step(0, 0, 0, 1, 0, 20, "R8");
    step(0, 0, 0, 1, 0, 20, "R8");

    // R9: late write to another address; older completed late entry is silent
    step(1, 21, 0, 0, 0, 20, "R9");
    step(1, 22, 32'h0000_0022, 1, 32'h0000_0021, 21, "R9");
    step(0, 0, 0, 1, 0, 21, "R9");

    // R10: writes and reads of entry 0, plus a late write to it
    step(1, 0, 32'h0000_00C0, 1, 0, 0, "R10");
    step(0, 0, 0, 1, 0, 0, "R10");
    step(1, 0, 0, 0, 0, 5, "R10");
    step(0, 0, 0, 1, 32'h0000_00C1, 0, "R10");
    step(0, 0, 0, 1, 0, 0, "R10");

    // Mixed traffic on a small address window: R2 R3 R5 R8 R9
    for (int n = 0; n < 400; n++) begin
      step(($urandom % 4) != 0, $urandom % 4, $urandom, ($urandom % 3) != 0,
           $urandom, $urandom % 4, "R2/R3/R5/R8 mix");
    end
    finish_run();
  end

endmodule